// File: doc/BRIEF.md
# Dual-Clock 9-bit FIFO with Reset-Selected Write-Enable Mode

This block buffers a stream of 9-bit words between two independent clock domains. Words enter on the rising edge of a write clock and leave on the rising edge of a read clock. The two clocks may be unrelated or identical. The storage holds 512 words by default. Both the depth and the word width are parameters. All enables and status flags are active low. The read side has a registered data output that is cleared by reset. An output-enable input is turned into a drive-enable output, so the block needs no tri-state bus.

One write-side pin has two uses, and reset chooses which. The block samples the pin on write-clock edges while reset is low:
- **Pin high during reset:** the pin becomes a second, active-high write enable. This mode suits depth expansion, where external logic steers writes between several FIFOs.
- **Pin low during reset:** the pin becomes a load strobe for an offset-register block that sits beside this FIFO. The FIFO flags offset accesses on two strobe outputs, and an offset access never moves a FIFO pointer.

Each pointer crosses to the other clock domain as a Gray code through a chain of synchronizer flops. The pointers carry one extra bit so that a full FIFO and an empty FIFO give different pointer values. The full flag is registered on the write clock and the empty flag on the read clock.

Top module: `fifo_dc9`

## Requirements
- R1: While `rstN` is low, both pointers go back to the first location, `fullN` reads 1 and `emptyN` reads 0. After reset, the first word written is the first word read.
- R2: While `rstN` is low, `rdData` is cleared to all zeros.
- R3: If `wrEn2Ld` is 1 during reset (two-enable mode), a word is written on a write-clock edge only when `wrEn1N`=0 and `wrEn2Ld`=1. With `wrEn1N`=0 and `wrEn2Ld`=0 nothing is written, and `offsetLoad` stays 0.
- R4: If `wrEn2Ld` is 0 during reset (offset mode), the following hold:
  - `wrEn1N`=0 with `wrEn2Ld`=1 writes a word.
  - `wrEn1N`=0 with `wrEn2Ld`=0 drives `offsetLoad`=1 and writes nothing.
  - `rdEn1N`=`rdEn2N`=0 with `wrEn2Ld`=0 drives `offsetRead`=1, leaves `rdData` unchanged and removes no word.
- R5: A read-clock edge loads the next word into `rdData` only when `rdEn1N`=0 and `rdEn2N`=0. If either enable is 1, `rdData` holds its value.
- R6: Write attempts are ignored while `fullN`=0, so no stored word is overwritten. Read attempts are ignored while `emptyN`=0, and `rdData` holds.
- R7: With no reads after reset, `fullN` is still 1 after DEPTH-1 writes and is 0 after exactly DEPTH writes (512 by default). `emptyN` goes to 0 on the read edge that removes the last stored word.
- R8: Words come out in the order they were accepted, whether the two clocks are equal or unrelated, and under arbitrary patterns of enables.
- R9: `rdDrive` equals the inverse of `outEnN`, and `outEnN` has no effect on `rdData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write clock |
| wrEn1N | input | 1 | Primary write enable, active low |
| wrEn2Ld | input | 1 | Second write enable (active high) or offset load strobe (active low), chosen during reset |
| wrData | input | 9 | Write data |
| rdClk | input | 1 | Read clock |
| rdEn1N | input | 1 | Read enable 1, active low |
| rdEn2N | input | 1 | Read enable 2, active low |
| outEnN | input | 1 | Output enable, active low |
| rstN | input | 1 | Asynchronous reset, active low; also the window in which the mode is sampled |
| rdData | output | 9 | Registered read data |
| rdDrive | output | 1 | High when the read data should be driven onto a bus |
| fullN | output | 1 | Full flag, active low, write-clock domain |
| emptyN | output | 1 | Empty flag, active low, read-clock domain |
| offsetLoad | output | 1 | Offset-register write strobe in offset mode |
| offsetRead | output | 1 | Offset-register read strobe in offset mode |

## Verification
A pointer that skips, repeats or crosses domains incorrectly has a visible effect at the ports. A word can arrive out of order or twice on `rdData`, or a stored word can be overwritten. The scoreboard sees this on the first read of the affected word. A wrong flag shows up in two ways: `fullN` changes on a write count other than DEPTH, or `emptyN` stays high when no data is left. Either shows as a queue mismatch or as a flag check within a few cycles of the event. A wrongly latched mode shows on the first write or read made with the dual-purpose pin low: a word is stored or removed that should not be, or an offset strobe is missing.

// File: rtl/fifo_dc9_pkg.sv
`timescale 1ns/1ps
package fifo_dc9_pkg;

  // Strobes from the control logic to the datapath; push is in the write domain, pop in the read domain.
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStb_t;

  // Function of the dual-purpose write pin, selected during reset.
  typedef enum logic {
    MODE_OFFSET = 1'b0,
    MODE_TWO_EN = 1'b1
  } fifoMode_t;

endpackage

// File: rtl/fifo_dc9_sync.sv
`timescale 1ns/1ps
module fifo_dc9_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/fifo_dc9_ctrl.sv
`timescale 1ns/1ps
module fifo_dc9_ctrl
  import fifo_dc9_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn1N,
  input  logic              wrEn2Ld,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  output fifoStb_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullN,
  output logic              emptyN,
  output logic              offsetLoad,
  output logic              offsetRead
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Mode latch: follows the dual-purpose pin while reset is held, frozen afterwards.
  fifoMode_t modeSel;
  always_ff @(posedge wrClk) begin
    if (!rstN) modeSel <= fifoMode_t'(wrEn2Ld);
  end

  logic twoEn;
  assign twoEn = (modeSel == MODE_TWO_EN);

  // Write side
  logic [PTR_W-1:0] wBin, wGray, wBinNext, wGrayNext, rGraySyncW;
  logic             wrReq;

  assign wrReq      = !wrEn1N && wrEn2Ld;
  assign stb.push   = wrReq && fullN;
  assign offsetLoad = !twoEn && !wrEn1N && !wrEn2Ld;
  assign wBinNext   = wBin + PTR_W'(stb.push);
  assign wGrayNext  = bin2gray(wBinNext);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin  <= '0;
      wGray <= '0;
      fullN <= 1'b1;
    end else begin
      wBin  <= wBinNext;
      wGray <= wGrayNext;
      fullN <= !(wGrayNext == {~rGraySyncW[PTR_W-1:PTR_W-2], rGraySyncW[PTR_W-3:0]});
    end
  end

  // Read side
  logic [PTR_W-1:0] rBin, rGray, rBinNext, rGrayNext, wGraySyncR;
  logic             rdReq;

  assign rdReq      = !rdEn1N && !rdEn2N && (twoEn || wrEn2Ld);
  assign stb.pop    = rdReq && emptyN;
  assign offsetRead = !twoEn && !rdEn1N && !rdEn2N && !wrEn2Ld;
  assign rBinNext   = rBin + PTR_W'(stb.pop);
  assign rGrayNext  = bin2gray(rBinNext);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rBin   <= '0;
      rGray  <= '0;
      emptyN <= 1'b0;
    end else begin
      rBin   <= rBinNext;
      rGray  <= rGrayNext;
      emptyN <= !(rGrayNext == wGraySyncR);
    end
  end

  fifo_dc9_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) uRdToWr (
    .clk(wrClk), .rstN(rstN), .din(rGray), .dout(rGraySyncW)
  );

  fifo_dc9_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) uWrToRd (
    .clk(rdClk), .rstN(rstN), .din(wGray), .dout(wGraySyncR)
  );

  assign wrAddr = wBin[ADDR_W-1:0];
  assign rdAddr = rBin[ADDR_W-1:0];

  // Checks on occupancy as each domain sees it
  logic [PTR_W-1:0] fillW, fillR;
  assign fillW = wBin - gray2bin(rGraySyncW);
  assign fillR = gray2bin(wGraySyncR) - rBin;

  p_no_overflow_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    fillW <= PTR_W'(DEPTH));

  p_full_at_depth_r7: assert property (@(posedge wrClk) disable iff (!rstN)
    (fillW == PTR_W'(DEPTH)) |-> !fullN);

  p_no_underflow_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    fillR <= PTR_W'(DEPTH));

  p_empty_at_zero_r7: assert property (@(posedge rdClk) disable iff (!rstN)
    (fillR == '0) |-> !emptyN);

  p_mode_frozen_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeSel));

  p_offload_nowrite_r4: assert property (@(posedge wrClk) disable iff (!rstN)
    offsetLoad |=> $stable(wBin));

endmodule

// File: rtl/fifo_dc9_dpath.sv
`timescale 1ns/1ps
module fifo_dc9_dpath
  import fifo_dc9_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 9
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (stb.pop) rdData <= mem[rdAddr];
  end

  assign rdDrive = !outEnN;

endmodule

// File: rtl/fifo_dc9.sv
`timescale 1ns/1ps
module fifo_dc9
  import fifo_dc9_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrEn1N,
  input  logic              wrEn2Ld,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic              outEnN,
  input  logic              rstN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              fullN,
  output logic              emptyN,
  output logic              offsetLoad,
  output logic              offsetRead
);

  fifoStb_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifo_dc9_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .emptyN(emptyN),
    .offsetLoad(offsetLoad), .offsetRead(offsetRead)
  );

  fifo_dc9_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive)
  );

  p_partial_en_hold_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn1N || rdEn2N) |=> $stable(rdData));

  p_empty_read_hold_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdData));

  p_offread_hold_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    offsetRead |=> $stable(rdData));

endmodule

// File: tb/fifo_dc9_test.sv
`timescale 1ns/1ps
module fifo_dc9_test;

  localparam int DEPTH = 512;

  logic       wrClk = 1'b0, rdClk = 1'b0;
  logic       wrEn1N = 1'b1, wrEn2Ld = 1'b1, rdEn1N = 1'b1, rdEn2N = 1'b1;
  logic       outEnN = 1'b1, rstN = 1'b0;
  logic [8:0] wrData = '0;
  logic [8:0] rdData;
  logic       rdDrive, fullN, emptyN, offsetLoad, offsetRead;

  realtime wrHalf = 5.0, rdHalf = 5.0;
  int checks = 0, failures = 0;
  logic [8:0] expQ [$];
  logic [8:0] lastRead = '0;

  initial forever #(wrHalf) wrClk = ~wrClk;
  initial forever #(rdHalf) rdClk = ~rdClk;

  fifo_dc9 uut (
    .wrClk(wrClk), .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .wrData(wrData),
    .rdClk(rdClk), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N), .outEnN(outEnN),
    .rstN(rstN), .rdData(rdData), .rdDrive(rdDrive), .fullN(fullN),
    .emptyN(emptyN), .offsetLoad(offsetLoad), .offsetRead(offsetRead)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic modePin);
    @(negedge wrClk);
    wrEn1N = 1'b1; rdEn1N = 1'b1; rdEn2N = 1'b1;
    wrEn2Ld = modePin;
    rstN = 1'b0;
    repeat (4) @(negedge wrClk);
    rstN = 1'b1;
    wrEn2Ld = 1'b1;
    expQ.delete();
    lastRead = '0;
    repeat (3) @(negedge wrClk);
  endtask

  task automatic writerRun(input int total, input int pct);
    int sent = 0;
    while (sent < total) begin
      @(negedge wrClk);
      wrEn1N = 1'b1; wrEn2Ld = 1'b1;
      if ($urandom_range(99) < pct) begin
        wrData = 9'($urandom);
        wrEn1N = 1'b0;
        if (fullN) begin
          expQ.push_back(wrData);
          sent++;
        end
      end else if ($urandom_range(99) < 30) begin
        wrData = 9'($urandom);
        wrEn1N = 1'b0; wrEn2Ld = 1'b0;   // second enable inactive: nothing may be stored
      end
    end
    @(negedge wrClk);
    wrEn1N = 1'b1; wrEn2Ld = 1'b1;
  endtask

  task automatic readerRun(input int total, input int pct);
    int got = 0;
    bit pend = 0, hold = 0;
    logic [8:0] e = '0;
    while (got < total || pend) begin
      @(negedge rdClk);
      if (pend) begin
        checkVal("R8 order", rdData, e);
        lastRead = e;
        pend = 0;
      end else if (hold) begin
        checkVal("R5 hold", rdData, lastRead);
      end
      hold = 0;
      rdEn1N = 1'b1; rdEn2N = 1'b1;
      if (got < total && $urandom_range(99) < pct) begin
        rdEn1N = 1'b0; rdEn2N = 1'b0;
        if (emptyN) begin
          if (expQ.size() == 0) begin
            checkVal("R6 empty flag high with nothing stored", 0, 1);
            hold = 1;
          end else begin
            e = expQ.pop_front();
            pend = 1;
            got++;
          end
        end else begin
          hold = 1;   // read attempt while empty
        end
      end else if ($urandom_range(99) < 30) begin
        if ($urandom_range(1) == 0) rdEn1N = 1'b0;
        else                        rdEn2N = 1'b0;
        hold = 1;
      end
    end
    rdEn1N = 1'b1; rdEn2N = 1'b1;
  endtask

  task automatic finishRun;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wrClk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    // Reset state, two-enable mode
    doReset(1'b1);
    checkVal("R1 fullN after reset", fullN, 1);
    checkVal("R1 emptyN after reset", emptyN, 0);
    checkVal("R2 rdData after reset", rdData, 0);

    // R9: drive enable follows the inverted output enable
    outEnN = 1'b0; #1;
    checkVal("R9 rdDrive with outEnN=0", rdDrive, 1);
    outEnN = 1'b1; #1;
    checkVal("R9 rdDrive with outEnN=1", rdDrive, 0);
    checkVal("R9 rdData unaffected", rdData, 0);
    outEnN = 1'b0;

    // R3: second enable low blocks writes, no offset strobe
    @(negedge wrClk);
    wrEn1N = 1'b0; wrEn2Ld = 1'b0; wrData = 9'h155;
    #1 checkVal("R3 offsetLoad in two-enable mode", offsetLoad, 0);
    repeat (4) @(negedge wrClk);
    wrEn1N = 1'b1; wrEn2Ld = 1'b1;
    repeat (6) @(negedge rdClk);
    checkVal("R3 no write with second enable low", emptyN, 0);

    // R7: fill to exactly DEPTH without reads
    for (int i = 0; i < DEPTH; i++) begin
      wrData = 9'(i * 7 + 3);
      wrEn1N = 1'b0; wrEn2Ld = 1'b1;
      if (fullN) expQ.push_back(wrData);
      @(negedge wrClk);
      if (i == DEPTH - 2) checkVal("R7 not full after DEPTH-1 writes", fullN, 1);
      if (i == DEPTH - 1) checkVal("R7 full after DEPTH writes", fullN, 0);
    end
    // R6: writes while full are ignored
    for (int i = 0; i < 3; i++) begin
      wrData = 9'h1F0 + 9'(i);
      @(negedge wrClk);
    end
    wrEn1N = 1'b1;
    checkVal("R6 queue holds DEPTH words", expQ.size(), DEPTH);
    readerRun(DEPTH, 100);
    repeat (2) @(negedge rdClk);
    checkVal("R7 empty after draining", emptyN, 0);
    checkVal("R6 no extra word stored", expQ.size(), 0);
    // R6: reads while empty hold the output
    rdEn1N = 1'b0; rdEn2N = 1'b0;
    repeat (3) @(negedge rdClk);
    rdEn1N = 1'b1; rdEn2N = 1'b1;
    checkVal("R6 rdData holds when empty", rdData, lastRead);

    // R5: partial enables hold the output
    writerRun(2, 100);
    repeat (6) @(negedge rdClk);
    rdEn1N = 1'b0; rdEn2N = 1'b1;
    repeat (3) @(negedge rdClk);
    checkVal("R5 hold with rdEn2N high", rdData, lastRead);
    rdEn1N = 1'b1; rdEn2N = 1'b0;
    repeat (3) @(negedge rdClk);
    checkVal("R5 hold with rdEn1N high", rdData, lastRead);
    rdEn1N = 1'b1; rdEn2N = 1'b1;
    readerRun(1, 100);
    checkVal("R5 one word left", expQ.size(), 1);

    // R2/R1: reset with data present clears output and flags; enter offset mode
    doReset(1'b0);
    checkVal("R2 rdData cleared by reset", rdData, 0);
    checkVal("R1 emptyN after mid-run reset", emptyN, 0);
    checkVal("R1 fullN after mid-run reset", fullN, 1);

    // R4: load strobe, no FIFO write
    @(negedge wrClk);
    wrEn1N = 1'b0; wrEn2Ld = 1'b0; wrData = 9'h0AA;
    #1 checkVal("R4 offsetLoad asserted", offsetLoad, 1);
    repeat (3) @(negedge wrClk);
    wrEn1N = 1'b1; wrEn2Ld = 1'b1;
    #1 checkVal("R4 offsetLoad released", offsetLoad, 0);
    repeat (6) @(negedge rdClk);
    checkVal("R4 load cycles store no word", emptyN, 0);
    writerRun(2, 100);
    repeat (6) @(negedge rdClk);
    checkVal("R4 write with strobe high stores", emptyN, 1);
    // R4: offset read removes nothing
    wrEn2Ld = 1'b0; rdEn1N = 1'b0; rdEn2N = 1'b0;
    #1 checkVal("R4 offsetRead asserted", offsetRead, 1);
    repeat (2) @(negedge rdClk);
    rdEn1N = 1'b1; rdEn2N = 1'b1; wrEn2Ld = 1'b1;
    checkVal("R4 rdData held during offset read", rdData, 0);
    readerRun(2, 100);   // R1: first word after reset comes out first

    // R8: random traffic, equal clocks
    doReset(1'b1);
    fork
      writerRun(600, 60);
      readerRun(600, 50);
    join

    // R8: unrelated clocks, slow reader (reaches full)
    rdHalf = 6.85;
    doReset(1'b1);
    fork
      writerRun(700, 80);
      readerRun(700, 35);
    join

    // R8: unrelated clocks, fast reader (reaches empty)
    rdHalf = 3.3;
    doReset(1'b1);
    fork
      writerRun(600, 40);
      readerRun(600, 70);
    join
    checkVal("R8 scoreboard drained", expQ.size(), 0);

    finishRun();
  end

endmodule